// File: doc/BRIEF.md
# Machine Trap Arbiter and Trap State Registers

This block decides, every clock cycle, whether the core takes a trap, and which one. Ten synchronous exception requests compete under a fixed priority, and all of them outrank sixteen fast interrupt lines. Each interrupt line is masked by its own enable bit and by a global machine interrupt enable. When a trap is taken, the block captures the cause code, the return address and a trap value in its registers, and it moves the interrupt-enable and privilege fields of the machine status word into their saved positions.

The return address comes either from the interrupted instruction, which has not been executed, or from the instruction that raised the exception. The trap value holds the instruction word, the data address that faulted, or zero, depending on the cause. A return-from-trap request restores the privilege level and the interrupt enable from the saved fields. A narrow status write port lets the surrounding control logic set the writable status fields. Decoding, vector address computation and debug handling belong to other blocks.

Top module: `trap_unit`

## Requirements
- R1: While reset is asserted, and until the first event after it, `mcause`, `mepc`, `mtval` and `mstatus` read zero, `priv` reads 2'b11 (machine) and `trap_taken` reads 0.
- R2: `exc_req` bit i has priority over every bit j > i. The bits, in index order, are fetch misaligned, fetch access fault, illegal instruction, machine environment call, user environment call, breakpoint, store misaligned, load misaligned, store access fault and load access fault. Their `mcause` codes are 0x0, 0x1, 0x2, 0xB, 0x8, 0x3, 0x6, 0x4, 0x7 and 0x5. The winner is registered one cycle after the request is sampled.
- R3: Interrupts are taken only when no exception is requested. Among pending channels, the lowest index n wins, and `mcause` becomes 0x80000010 + n.
- R4: `mepc` takes `pc_intr` for fetch misaligned, for fetch access fault and for every interrupt. For every other exception it takes `pc_exec`.
- R5: `mtval` takes `instr_word` for an illegal instruction and `data_addr` for the four load/store misaligned and access faults. It takes zero for every other exception and for every interrupt.
- R6: On a taken trap, `trap_taken` is 1 for that one registered cycle. MPIE (bit 7) takes the old MIE (bit 3), MIE becomes 0, MPP (bits 12:11) takes the old privilege (11 for machine, 00 for user) and `priv` becomes 2'b11.
- R7: When `ret_req` is set and no trap is taken, `priv` takes the MPP value, MIE takes MPIE and MPIE becomes 1. MPRV (bit 17) is cleared when the restored privilege is user. A trap taken in the same cycle overrides the return.
- R8: An interrupt line n is taken only if `irq_line[n]` and `irq_en[n]` are both set, and MIE is 1 or `priv` is user. Otherwise no trap is taken and no register changes.
- R9: When `status_we` is set and neither a trap nor a return occurs, `status_wdata` bits 3, 7, 17 and 21 load MIE, MPIE, MPRV and TW. MPP becomes 11 only if both bits 12 and 11 are set, and 00 otherwise. Every other bit of `mstatus` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 10 | Exception requests, bit 0 highest priority |
| irq_line | input | NUM_IRQ | Fast interrupt lines |
| irq_en | input | NUM_IRQ | Per-channel interrupt enables |
| pc_exec | input | 32 | Address of the executing instruction |
| pc_intr | input | 32 | Address of the next, not yet executed instruction |
| instr_word | input | 32 | Decompressed instruction word |
| data_addr | input | 32 | Faulting data access address |
| ret_req | input | 1 | Return-from-trap request |
| status_we | input | 1 | Status field write strobe |
| status_wdata | input | 32 | Status write data |
| trap_taken | output | 1 | A trap was taken at the last edge |
| mcause | output | 32 | Trap cause code |
| mepc | output | 32 | Trap return address |
| mtval | output | 32 | Trap value |
| mstatus | output | 32 | Machine status word |
| priv | output | 2 | Current privilege, 11 machine, 00 user |

## Verification
If the priority order is wrong or the saved state is corrupted, the fault shows up at the ports one clock edge after the offending request. A wrong winner shows as a wrong `mcause`, and a wrong operand select shows in `mepc` or `mtval`. A broken save or restore of MIE, MPIE or MPP may stay hidden until a later return or interrupt. At that point it appears as a wrong `priv` or as an interrupt that is taken or refused against the gating rule. For this reason, long random runs mix traps, returns and status writes so that saved state is used again many cycles after it was captured.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int XLEN    = 32;
    localparam int NUM_EXC = 10;
    localparam int EXC_W   = $clog2(NUM_EXC);

    // status word bit positions decoded by neighbouring logic
    localparam int ST_MIE  = 3;
    localparam int ST_MPIE = 7;
    localparam int ST_MPPL = 11;
    localparam int ST_MPPH = 12;
    localparam int ST_MPRV = 17;
    localparam int ST_TW   = 21;

    typedef enum logic [1:0] {
        TVAL_ZERO,
        TVAL_INSTR,
        TVAL_ADDR
    } tval_sel_e;

    typedef struct packed {
        logic            taken;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] tval;
        logic            mie;
        logic            mpie;
        logic            mpp_m;
        logic            mprv;
        logic            tw;
        logic            priv_m;
    } trap_state_t;

    // cause code of each exception slot, slot order is priority order
    function automatic logic [XLEN-1:0] exc_cause(input logic [EXC_W-1:0] slot);
        case (slot)
            4'd0:    exc_cause = XLEN'(4'h0);
            4'd1:    exc_cause = XLEN'(4'h1);
            4'd2:    exc_cause = XLEN'(4'h2);
            4'd3:    exc_cause = XLEN'(4'hB);
            4'd4:    exc_cause = XLEN'(4'h8);
            4'd5:    exc_cause = XLEN'(4'h3);
            4'd6:    exc_cause = XLEN'(4'h6);
            4'd7:    exc_cause = XLEN'(4'h4);
            4'd8:    exc_cause = XLEN'(4'h7);
            default: exc_cause = XLEN'(4'h5);
        endcase
    endfunction

    function automatic tval_sel_e exc_tval_sel(input logic [EXC_W-1:0] slot);
        if (slot == 4'd2)
            exc_tval_sel = TVAL_INSTR;
        else if (slot >= 4'd6)
            exc_tval_sel = TVAL_ADDR;
        else
            exc_tval_sel = TVAL_ZERO;
    endfunction

    // fetch-side faults report the not-yet-executed address
    function automatic logic exc_uses_next_pc(input logic [EXC_W-1:0] slot);
        exc_uses_next_pc = (slot < 4'd2);
    endfunction
endpackage

// File: rtl/trap_prio_enc.sv
module trap_prio_enc #(
    parameter int N  = 16,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i])
                idx = IW'(i);
        end
        valid = |req;
    end
endmodule

// File: rtl/trap_info_mux.sv
module trap_info_mux
    import trap_pkg::*;
#(
    parameter int NUM_IRQ  = 16,
    parameter int IRQ_BASE = 16,
    parameter int IRQ_W    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic             exc_valid,
    input  logic [EXC_W-1:0] exc_idx,
    input  logic [IRQ_W-1:0] irq_idx,
    input  logic [XLEN-1:0]  pc_exec,
    input  logic [XLEN-1:0]  pc_intr,
    input  logic [XLEN-1:0]  instr_word,
    input  logic [XLEN-1:0]  data_addr,
    output logic [XLEN-1:0]  cause,
    output logic [XLEN-1:0]  epc,
    output logic [XLEN-1:0]  tval
);
    localparam logic [XLEN-1:0] IRQ_BASE_V = XLEN'(IRQ_BASE);

    logic [XLEN-1:0] irq_num;
    tval_sel_e       sel;

    always_comb begin
        irq_num = XLEN'(irq_idx);
        if (exc_valid) begin
            cause = exc_cause(exc_idx);
            epc   = exc_uses_next_pc(exc_idx) ? pc_intr : pc_exec;
            sel   = exc_tval_sel(exc_idx);
        end else begin
            cause = {1'b1, IRQ_BASE_V[XLEN-2:0] + irq_num[XLEN-2:0]};
            epc   = pc_intr;
            sel   = TVAL_ZERO;
        end
        case (sel)
            TVAL_INSTR: tval = instr_word;
            TVAL_ADDR:  tval = data_addr;
            default:    tval = '0;
        endcase
    end
endmodule

// File: rtl/trap_unit.sv
module trap_unit
    import trap_pkg::*;
#(
    parameter int NUM_IRQ  = 16,
    parameter int IRQ_BASE = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXC-1:0] exc_req,
    input  logic [NUM_IRQ-1:0] irq_line,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic [XLEN-1:0]    pc_exec,
    input  logic [XLEN-1:0]    pc_intr,
    input  logic [XLEN-1:0]    instr_word,
    input  logic [XLEN-1:0]    data_addr,
    input  logic               ret_req,
    input  logic               status_we,
    input  logic [XLEN-1:0]    status_wdata,
    output logic               trap_taken,
    output logic [XLEN-1:0]    mcause,
    output logic [XLEN-1:0]    mepc,
    output logic [XLEN-1:0]    mtval,
    output logic [XLEN-1:0]    mstatus,
    output logic [1:0]         priv
);
    localparam int IRQ_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    trap_state_t      st_d, st_q;
    logic [NUM_IRQ-1:0] irq_pend;
    logic             exc_valid, irq_valid, irq_ok, take;
    logic [EXC_W-1:0] exc_idx;
    logic [IRQ_W-1:0] irq_idx;
    logic [XLEN-1:0]  sel_cause, sel_epc, sel_tval;

    // per-channel masking
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq_mask
        assign irq_pend[g] = irq_line[g] & irq_en[g];
    end

    trap_prio_enc #(.N(NUM_EXC), .IW(EXC_W)) u_exc_enc (
        .req   (exc_req),
        .valid (exc_valid),
        .idx   (exc_idx)
    );

    trap_prio_enc #(.N(NUM_IRQ), .IW(IRQ_W)) u_irq_enc (
        .req   (irq_pend),
        .valid (irq_valid),
        .idx   (irq_idx)
    );

    trap_info_mux #(.NUM_IRQ(NUM_IRQ), .IRQ_BASE(IRQ_BASE), .IRQ_W(IRQ_W)) u_info (
        .exc_valid  (exc_valid),
        .exc_idx    (exc_idx),
        .irq_idx    (irq_idx),
        .pc_exec    (pc_exec),
        .pc_intr    (pc_intr),
        .instr_word (instr_word),
        .data_addr  (data_addr),
        .cause      (sel_cause),
        .epc        (sel_epc),
        .tval       (sel_tval)
    );

    always_comb begin
        st_d       = st_q;
        st_d.taken = 1'b0;
        irq_ok     = st_q.mie | ~st_q.priv_m;
        take       = exc_valid | (irq_valid & irq_ok);
        if (take) begin
            st_d.taken  = 1'b1;
            st_d.cause  = sel_cause;
            st_d.epc    = sel_epc;
            st_d.tval   = sel_tval;
            st_d.mpie   = st_q.mie;
            st_d.mie    = 1'b0;
            st_d.mpp_m  = st_q.priv_m;
            st_d.priv_m = 1'b1;
        end else if (ret_req) begin
            st_d.priv_m = st_q.mpp_m;
            st_d.mie    = st_q.mpie;
            st_d.mpie   = 1'b1;
            if (!st_q.mpp_m)
                st_d.mprv = 1'b0;
        end else if (status_we) begin
            st_d.mie   = status_wdata[ST_MIE];
            st_d.mpie  = status_wdata[ST_MPIE];
            st_d.mpp_m = status_wdata[ST_MPPH] & status_wdata[ST_MPPL];
            st_d.mprv  = status_wdata[ST_MPRV];
            st_d.tw    = status_wdata[ST_TW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.priv_m <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        mstatus          = '0;
        mstatus[ST_MIE]  = st_q.mie;
        mstatus[ST_MPIE] = st_q.mpie;
        mstatus[ST_MPPL] = st_q.mpp_m;
        mstatus[ST_MPPH] = st_q.mpp_m;
        mstatus[ST_MPRV] = st_q.mprv;
        mstatus[ST_TW]   = st_q.tw;
    end

    assign trap_taken = st_q.taken;
    assign mcause     = st_q.cause;
    assign mepc       = st_q.epc;
    assign mtval      = st_q.tval;
    assign priv       = {2{st_q.priv_m}};
endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk
    import trap_pkg::*;
#(
    parameter int NUM_IRQ = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_EXC-1:0] exc_req,
    input logic [NUM_IRQ-1:0] irq_line,
    input logic [NUM_IRQ-1:0] irq_en,
    input logic [XLEN-1:0]    pc_intr,
    input logic               ret_req,
    input logic               trap_taken,
    input logic [XLEN-1:0]    mcause,
    input logic [XLEN-1:0]    mepc,
    input logic [XLEN-1:0]    mtval,
    input logic [XLEN-1:0]    mstatus,
    input logic [1:0]         priv
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R6
    entry_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> (priv == 2'b11 && !mstatus[ST_MIE]));

    // R6
    entry_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && trap_taken) |-> (mstatus[ST_MPIE] == $past(mstatus[ST_MIE])
                                     && mstatus[ST_MPPH:ST_MPPL] == $past(priv)));

    // R4
    irq_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && trap_taken && mcause[XLEN-1]) |-> mepc == $past(pc_intr));

    // R5
    irq_tval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken && mcause[XLEN-1]) |-> mtval == '0);

    // R3
    irq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken && mcause[XLEN-1]) |-> (mcause[XLEN-2:0] >= 31'd16
                                            && mcause[XLEN-2:0] < 31'd16 + 31'(NUM_IRQ)));

    // R7
    ret_mpie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(ret_req) && !trap_taken) |-> mstatus[ST_MPIE]);

    // R8
    idle_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(exc_req == '0 && (irq_line & irq_en) == '0)) |-> !trap_taken);

    // R9
    mpp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mstatus[ST_MPPH] == mstatus[ST_MPPL]);
endmodule

bind trap_unit trap_unit_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .exc_req    (exc_req),
    .irq_line   (irq_line),
    .irq_en     (irq_en),
    .pc_intr    (pc_intr),
    .ret_req    (ret_req),
    .trap_taken (trap_taken),
    .mcause     (mcause),
    .mepc       (mepc),
    .mtval      (mtval),
    .mstatus    (mstatus),
    .priv       (priv)
);

// File: tb/trap_unit_bench.sv
`timescale 1ns/1ps
module trap_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  exc_req = '0;
    logic [15:0] irq_line = '0, irq_en = '0;
    logic [31:0] pc_exec = '0, pc_intr = '0, instr_word = '0, data_addr = '0;
    logic        ret_req = 1'b0, status_we = 1'b0;
    logic [31:0] status_wdata = '0;
    logic        trap_taken;
    logic [31:0] mcause, mepc, mtval, mstatus;
    logic [1:0]  priv;

    always #2.5 clk = ~clk;

    trap_unit u_trap_unit (.*);

    int total = 0, bad = 0;
    bit done = 0;

    // reference state
    bit m_mie, m_mpie, m_mpp_m, m_mprv, m_tw, m_priv_m, m_taken;
    logic [31:0] m_cause, m_epc, m_tval;
    logic [31:0] code_tab [10] = '{32'h0, 32'h1, 32'h2, 32'hB, 32'h8,
                                   32'h3, 32'h6, 32'h4, 32'h7, 32'h5};

    function automatic logic [31:0] exp_status();
        logic [31:0] s = '0;
        s[3] = m_mie; s[7] = m_mpie; s[11] = m_mpp_m; s[12] = m_mpp_m;
        s[17] = m_mprv; s[21] = m_tw;
        return s;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_update();
        logic [15:0] pend = irq_line & irq_en;
        bit take = 0;
        m_taken = 0;
        if (exc_req != 0) begin
            int k = 0;
            while (!exc_req[k]) k++;
            m_cause = code_tab[k];
            m_epc   = (k < 2) ? pc_intr : pc_exec;
            m_tval  = (k == 2) ? instr_word : (k >= 6) ? data_addr : 32'h0;
            take = 1;
        end else if (pend != 0 && (m_mie || !m_priv_m)) begin
            int n = 0;
            while (!pend[n]) n++;
            m_cause = 32'h8000_0010 + n;
            m_epc   = pc_intr;
            m_tval  = 0;
            take = 1;
        end
        if (take) begin
            m_taken = 1; m_mpie = m_mie; m_mie = 0; m_mpp_m = m_priv_m; m_priv_m = 1;
        end else if (ret_req) begin
            m_priv_m = m_mpp_m; m_mie = m_mpie; m_mpie = 1;
            if (!m_mpp_m) m_mprv = 0;
        end else if (status_we) begin
            m_mie = status_wdata[3]; m_mpie = status_wdata[7];
            m_mpp_m = status_wdata[12] & status_wdata[11];
            m_mprv = status_wdata[17]; m_tw = status_wdata[21];
        end
    endtask

    // drive at negedge, update model at posedge, compare at next negedge
    task automatic step(logic [9:0] e, logic [15:0] il, logic [15:0] ie,
                        bit rt, bit we, logic [31:0] wd);
        string ct, st;
        exc_req = e; irq_line = il; irq_en = ie; ret_req = rt;
        status_we = we; status_wdata = wd;
        pc_exec = $urandom; pc_intr = $urandom; instr_word = $urandom; data_addr = $urandom;
        ct = (e != 0) ? "R2" : "R3";
        st = (m_taken) ? "R6" : "R8";
        @(posedge clk);
        model_update();
        st = m_taken ? "R6" : rt ? "R7" : we ? "R9" : "R8";
        @(negedge clk);
        check(m_taken ? "R6" : "R8", "trap_taken", 32'(trap_taken), 32'(m_taken));
        check(ct, "mcause", mcause, m_cause);
        check("R4", "mepc", mepc, m_epc);
        check("R5", "mtval", mtval, m_tval);
        check(st, "mstatus", mstatus, exp_status());
        check(st, "priv", 32'(priv), m_priv_m ? 32'd3 : 32'd0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        m_mie = 0; m_mpie = 0; m_mpp_m = 0; m_mprv = 0; m_tw = 0; m_priv_m = 1; m_taken = 0;
        m_cause = 0; m_epc = 0; m_tval = 0;
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1", "mcause", mcause, 0);
        check("R1", "mepc", mepc, 0);
        check("R1", "mtval", mtval, 0);
        check("R1", "mstatus", mstatus, 0);
        check("R1", "priv", 32'(priv), 3);
        check("R1", "trap_taken", 32'(trap_taken), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: interrupt refused in machine mode with MIE clear
        step('0, 16'h0001, 16'h0001, 0, 0, 0);
        check("R8", "no irq trap M/MIE=0", 32'(trap_taken), 0);
        // R9: full write, legal fields only
        step('0, '0, '0, 0, 1, 32'hFFFF_FFFF);
        check("R9", "status full write", mstatus, 32'h0022_1888);
        // R9: MPP=01 is read back as 00
        step('0, '0, '0, 0, 1, 32'h0002_0888);
        check("R9", "mpp partial", mstatus, 32'h0002_0088);
        // R7: return to user clears MPRV
        step('0, '0, '0, 1, 0, 0);
        check("R7", "ret priv", 32'(priv), 0);
        check("R7", "ret mprv cleared", 32'(mstatus[17]), 0);
        // R8: enabled but masked channel is ignored
        step('0, 16'h0004, 16'h0003, 0, 0, 0);
        check("R8", "masked line", 32'(trap_taken), 0);
        // R3: in user mode lowest pending channel wins
        step('0, 16'h8030, 16'hFFFF, 0, 0, 0);
        check("R3", "irq 4 code", mcause, 32'h8000_0014);
        // R2: exceptions in each slot, and all together
        for (int k = 0; k < 10; k++) step(10'(1 << k), 16'hFFFF, 16'hFFFF, 0, 0, 0);
        step(10'h3FF, 16'hFFFF, 16'hFFFF, 1, 1, 0);
        check("R2", "all exceptions", mcause, 32'h0);
        step(10'h200, '0, '0, 0, 0, 0);
        check("R5", "load fault tval", mtval, data_addr);
        // R7: trap overrides simultaneous return
        step(10'h020, '0, '0, 1, 0, 0);
        check("R7", "trap beats return", mcause, 32'h3);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [9:0] e = (($urandom % 6) == 0) ? 10'($urandom) : '0;
            step(e, 16'($urandom) & 16'($urandom), 16'($urandom),
                 ($urandom % 5) == 0, ($urandom % 7) == 0, $urandom);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule